// File: doc/BRIEF.md
# Boundary-Register Common/Bank Mapper

This block sits between a 16-bit CPU address bus and a wider physical memory. It splits the CPU space in two with a boundary held in a register. Pages below the boundary form the banked window. Each banked access is relocated by adding a bank base, counted in 4 KB pages. Pages at or above the boundary form the common window, which is relocated by its own base.

There are two banked bases: one for reads and one for writes. Software normally keeps them equal. A single port write loads both, so a bank switch costs one I/O write. When the two bases differ, a block copy loop reads from one bank and writes into another. Translation is combinational. A register write takes effect from the clock edge that captures it.

Top module: `bank_mapper`

## Requirements
- R1: After synchronous reset the boundary is page 15 (F000h) and the read, write and common bases are all 0, so `phys_addr` equals `cpu_addr` zero-extended to 20 bits.
- R2: An I/O write with `io_sel` = 0 loads the boundary from `io_data[3:0]`. The new value takes effect from the next clock edge.
- R3: A CPU address whose upper 4 bits are below the boundary is banked and drives `phys_common` low. Any other address is common and drives `phys_common` high.
- R4: A banked address maps to `(base << 12) + cpu_addr` modulo 2^20. The base is the write base while `cpu_wr` is high, and the read base otherwise.
- R5: A common address maps to `(common_base << 12) + cpu_addr` modulo 2^20.
- R6: `io_sel` = 1 loads only the read base from `io_data`. `io_sel` = 2 loads only the write base.
- R7: `io_sel` = 3 loads the read base and the write base with the same value in a single write.
- R8: `io_sel` = 4 loads the common base from `io_data`.
- R9: Writes with `io_sel` of 5, 6 or 7 change no register. No mapping changes as a result.
- R10: A boundary of 0 makes every CPU address common.
- R11: The low 12 bits of `phys_addr` always equal the low 12 bits of `cpu_addr`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Register write strobe |
| io_sel | input | 3 | Register select: 0 boundary, 1 read base, 2 write base, 3 both bases, 4 common base |
| io_data | input | 8 | Register write data |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | High when the current access is a write |
| phys_addr | output | 20 | Translated physical address |
| phys_common | output | 1 | High when the address falls in the common window |

## Verification
Each configuration is swept over all 16 CPU pages, at three offsets and in both access directions. The offsets are the first byte, a middle byte and the last byte of a page. Distinct read, write and common bases show whether the right base was picked on each side of the boundary. A base of FFh exposes wrap-around in the adder. A boundary of 0 shows that the whole space turns common. Writes to unused selects followed by a full sweep show that those writes reached no register.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

    parameter int CPU_AW  = 16;
    parameter int PG_BITS = 12;
    parameter int BASE_W  = 8;
    parameter int SEL_W   = 3;

    localparam int PAGE_W = CPU_AW - PG_BITS;
    localparam int PA_W   = BASE_W + PG_BITS;

    typedef enum logic [SEL_W-1:0] {
        SEL_BOUND = 3'd0,
        SEL_RBASE = 3'd1,
        SEL_WBASE = 3'd2,
        SEL_BOTH  = 3'd3,
        SEL_CBASE = 3'd4
    } map_sel_e;

    typedef struct packed {
        logic [PAGE_W-1:0] bound;
        logic [BASE_W-1:0] rd_base;
        logic [BASE_W-1:0] wr_base;
        logic [BASE_W-1:0] com_base;
    } map_cfg_t;

    typedef struct packed {
        logic            common;
        logic [PA_W-1:0] addr;
    } map_out_t;

    localparam map_cfg_t CFG_RESET = '{bound: '1, rd_base: '0, wr_base: '0, com_base: '0};

    function automatic logic [PAGE_W-1:0] page_of(input logic [CPU_AW-1:0] a);
        return a[CPU_AW-1:PG_BITS];
    endfunction

    function automatic logic [PA_W-1:0] relocate(input logic [BASE_W-1:0] base,
                                                 input logic [CPU_AW-1:0] a);
        return {base, {PG_BITS{1'b0}}} + PA_W'(a);
    endfunction

endpackage

// File: rtl/bank_mapper_regs.sv
module bank_mapper_regs
    import bank_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  sel,
    input  logic [BASE_W-1:0] data,
    output map_cfg_t          cfg
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (wr_en) begin
            case (sel)
                SEL_BOUND: cfg.bound    <= data[PAGE_W-1:0];
                SEL_RBASE: cfg.rd_base  <= data;
                SEL_WBASE: cfg.wr_base  <= data;
                SEL_BOTH: begin
                    cfg.rd_base <= data;
                    cfg.wr_base <= data;
                end
                SEL_CBASE: cfg.com_base <= data;
                default: ;
            endcase
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (cfg == CFG_RESET));

    assert_unused_sel_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!wr_en || sel > SEL_W'(SEL_CBASE)) |=> $stable(cfg));

    assert_both_equal_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_W'(SEL_BOTH)) |=> (cfg.rd_base == cfg.wr_base && cfg.rd_base == $past(data)));

    assert_rbase_only_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && sel == SEL_W'(SEL_RBASE)) |=> ($stable(cfg.wr_base) && $stable(cfg.bound) && $stable(cfg.com_base)));

endmodule

// File: rtl/bank_mapper_xlate.sv
module bank_mapper_xlate
    import bank_mapper_pkg::*;
(
    input  map_cfg_t          cfg,
    input  logic [CPU_AW-1:0] addr,
    input  logic              is_wr,
    output map_out_t          res
);

    logic              in_common;
    logic [BASE_W-1:0] bank_base;
    logic [BASE_W-1:0] use_base;

    always_comb begin
        in_common  = (page_of(addr) >= cfg.bound);
        bank_base  = is_wr ? cfg.wr_base : cfg.rd_base;
        use_base   = in_common ? cfg.com_base : bank_base;
        res.common = in_common;
        res.addr   = relocate(use_base, addr);
    end

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              io_wr,
    input  logic [SEL_W-1:0]  io_sel,
    input  logic [BASE_W-1:0] io_data,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_wr,
    output logic [PA_W-1:0]   phys_addr,
    output logic              phys_common
);

    map_cfg_t cfg;
    map_out_t res;

    bank_mapper_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr_en (io_wr),
        .sel   (io_sel),
        .data  (io_data),
        .cfg   (cfg)
    );

    bank_mapper_xlate u_xlate (
        .cfg   (cfg),
        .addr  (cpu_addr),
        .is_wr (cpu_wr),
        .res   (res)
    );

    assign phys_addr   = res.addr;
    assign phys_common = res.common;

    assert_offset_pass_R11: assert property (@(posedge clk) disable iff (rst)
        phys_addr[PG_BITS-1:0] == cpu_addr[PG_BITS-1:0]);

    assert_zero_bound_common_R10: assert property (@(posedge clk) disable iff (rst)
        (cfg.bound == '0) |-> phys_common);

    assert_bound_load_R2: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_sel == SEL_W'(SEL_BOUND)) |=> (cfg.bound == $past(io_data[PAGE_W-1:0])));

endmodule

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        io_wr;
    logic [2:0]  io_sel;
    logic [7:0]  io_data;
    logic [15:0] cpu_addr;
    logic        cpu_wr;
    logic [19:0] phys_addr;
    logic        phys_common;

    int checks   = 0;
    int failures = 0;

    logic [3:0] m_bnd;
    logic [7:0] m_rb, m_wb, m_cb;

    always #4 clk = ~clk;

    bank_mapper u_bank_mapper (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_sel(io_sel), .io_data(io_data),
        .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .phys_addr(phys_addr), .phys_common(phys_common)
    );

    task automatic reg_write(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_sel = s; io_data = d;
        @(negedge clk);
        io_wr = 1'b0;
        case (s)
            3'd0: m_bnd = d[3:0];
            3'd1: m_rb = d;
            3'd2: m_wb = d;
            3'd3: begin m_rb = d; m_wb = d; end
            3'd4: m_cb = d;
            default: ;
        endcase
    endtask

    task automatic probe(input string tag, input logic [15:0] a, input logic w);
        logic        exp_com;
        logic [7:0]  base;
        logic [19:0] exp_pa;
        cpu_addr = a; cpu_wr = w;
        #1;
        exp_com = (a[15:12] >= m_bnd);
        base    = exp_com ? m_cb : (w ? m_wb : m_rb);
        exp_pa  = 20'({base, 12'h000} + {4'h0, a});
        checks++;
        if (phys_common !== exp_com) begin
            failures++;
            $display("FAIL %s R3 common addr=%h wr=%0d actual=%0d expected=%0d", tag, a, w, phys_common, exp_com);
        end
        checks++;
        if (phys_addr !== exp_pa) begin
            failures++;
            $display("FAIL %s %s addr=%h wr=%0d actual=%h expected=%h", tag,
                     exp_com ? "R5" : "R4", a, w, phys_addr, exp_pa);
        end
        checks++;
        if (phys_addr[11:0] !== a[11:0]) begin
            failures++;
            $display("FAIL %s R11 offset actual=%h expected=%h", tag, phys_addr[11:0], a[11:0]);
        end
    endtask

    task automatic sweep(input string tag);
        logic [11:0] offs [3];
        offs[0] = 12'h000; offs[1] = 12'hABC; offs[2] = 12'hFFF;
        @(negedge clk);
        for (int p = 0; p < 16; p++)
            for (int o = 0; o < 3; o++)
                for (int w = 0; w < 2; w++)
                    probe(tag, {4'(p), offs[o]}, w[0]);
    endtask

    initial begin
        #(8 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; io_wr = 1'b0; io_sel = '0; io_data = '0; cpu_addr = '0; cpu_wr = 1'b0;
        m_bnd = 4'hF; m_rb = '0; m_wb = '0; m_cb = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        sweep("R1_reset_identity");

        reg_write(3'd0, 8'h08);
        reg_write(3'd1, 8'h10);
        reg_write(3'd2, 8'h20);
        reg_write(3'd4, 8'h80);
        sweep("R2_R6_R8_split");

        reg_write(3'd3, 8'h33);
        sweep("R7_both_bases");

        reg_write(3'd5, 8'h0F);
        reg_write(3'd6, 8'h77);
        reg_write(3'd7, 8'h00);
        sweep("R9_unused_selects");

        reg_write(3'd0, 8'h0C);
        reg_write(3'd1, 8'hFF);
        reg_write(3'd2, 8'hF8);
        reg_write(3'd4, 8'hFE);
        sweep("R4_R5_wrap");

        reg_write(3'd0, 8'h00);
        sweep("R10_all_common");

        reg_write(3'd0, 8'h01);
        sweep("R3_bound_one");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule